// File: doc/BRIEF.md
# Dual-Priority Nesting Interrupt Controller

This block arbitrates four interrupt sources, numbered 0 to 3 and standing for levels L1 to L4. It keeps apart two orderings. Response priority is fixed in hardware and decides which pending, unmasked request is offered to the processor first. Processing priority decides which running service routine may be preempted by which source. It is held as four mask words, one row per source, and each row blocks the columns of the sources that row's routine must not be interrupted by.

Requests are latched into pending bits only on cycles where the instruction-boundary strobe is high. The controller raises `irq_o` together with the source number of the best candidate. The processor takes it with `ack_i`. This is a valid/ready pair: `irq_o` and `grant_id_o` stay stable until the acknowledge or until a change in mask or pending state, and the acknowledge is ignored while `irq_o` is low. On acceptance the running level and its mask are pushed onto a four-entry nesting stack, and the granted source's mask word becomes the current mask. The end-of-service strobe pops the stack, so control unwinds level by level back to the main program, where the mask is all zeros.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the current mask is 0000, the nesting depth is 0 and `irq_o` is low.
- R2: A request line sets its pending bit only in a cycle where `boundary_i` is high. A pending bit stays set until that source is granted.
- R3: `irq_o` is high exactly when `gate_i` is high and some pending bit is not set in the current mask. `grant_id_o` is then the lowest-numbered such source (source 0 has the highest response priority).
- R4: An acknowledge taken while `irq_o` is high clears the granted pending bit, pushes the running context, raises the depth by one and loads the granted source's mask row into the current mask. An acknowledge while `irq_o` is low changes nothing.
- R5: The mask rows reset to the processing order 0 > 3 > 2 > 1. Each row blocks its own source and every source of equal or lower processing rank. Bit k stands for source k: row0=1111, row1=0010, row2=0110, row3=1110.
- R6: End of service at a depth above zero restores the previous mask and lowers the depth by one. At depth 0 it is ignored. If end of service and acknowledge come in the same cycle, end of service wins and the acknowledge has no effect.
- R7: A write through the mask port replaces row `mask_row_i` with `mask_data_i`. The change takes effect at that source's next grant and leaves the currently loaded mask unchanged.
- R8: The depth never exceeds 4. An acknowledge at depth 4 is ignored, and its pending bit is kept.
- R9: While `gate_i` is low, `irq_o` stays low and acknowledges are ignored, but requests still become pending.
- R10: Sources 0, 2 and 3 pending together, with source 1 arriving while source 2 is in service, are served in the order 0, 2, 3 (preempting 2), back to 2, then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Request lines, bit k is source k |
| boundary_i | input | 1 | Instruction-boundary strobe; requests are sampled here |
| ack_i | input | 1 | Interrupt acknowledge (ready for `irq_o`) |
| eos_i | input | 1 | End-of-service strobe |
| gate_i | input | 1 | Global interrupt enable |
| mask_we_i | input | 1 | Mask row write enable |
| mask_row_i | input | 2 | Mask row to write |
| mask_data_i | input | 4 | Mask row contents, bit k blocks source k |
| irq_o | output | 1 | Interrupt request (valid) |
| grant_id_o | output | 2 | Source offered by `irq_o` |
| mask_o | output | 4 | Current mask |
| depth_o | output | 3 | Nesting depth, 0 to 4 |

## Verification
The bench enters each source's routine from the main program and offers every source as a new request, so all sixteen row/column pairs of the default masks are checked against masks it computes from the processing ranks. An inverted or shifted row would let a routine be preempted by a lower-ranked source, or would freeze out a higher-ranked one. It replays the preemption scenario, where a design that restored the wrong mask on return would serve source 1 before source 2 finished. It also fills the stack with self-unmasking rows to hit the depth cap, where an unguarded design would wrap the depth to 0. Finally it presses end of service and acknowledge together, and exercises requests outside a boundary and with the global gate closed; designs that got these wrong would grant early or lose pending requests.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned ID_W  = 2,
  parameter logic [N_SRC*ID_W-1:0] PROC_RANK = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ID_W-1:0]          row,
  input  logic [N_SRC-1:0]         data,
  output logic [N_SRC*N_SRC-1:0]   rows_o
);
  logic [N_SRC-1:0] rows_q [N_SRC];

  // reset row r blocks every source whose processing rank is not better than r's
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_SRC; r++)
        for (int c = 0; c < N_SRC; c++)
          rows_q[r][c] <= (PROC_RANK[c*ID_W +: ID_W] >= PROC_RANK[r*ID_W +: ID_W]);
    end else if (we) begin
      rows_q[row] <= data;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign rows_o[g*N_SRC +: N_SRC] = rows_q[g];
  end
endmodule

// File: rtl/irq_resp_pick.sv
module irq_resp_pick #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned ID_W  = 2
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [ID_W-1:0]  id
);
  // lowest index has highest response priority
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_nest_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  stk_op_e                     op,
  input  logic [W-1:0]                din,
  output logic [W-1:0]                top_o,
  output logic [$clog2(DEPTH+1)-1:0]  cnt_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] top_idx;

  assign top_idx = AW'(cnt_q - CW'(1));
  assign top_o   = (cnt_q != '0) ? mem[top_idx] : '0;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (op)
        STK_PUSH: if (cnt_q < CW'(DEPTH)) begin
          mem[AW'(cnt_q)] <= din;
          cnt_q           <= cnt_q + CW'(1);
        end
        STK_POP: if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter logic [N_SRC*$clog2(N_SRC)-1:0] PROC_RANK = {2'd1, 2'd2, 2'd3, 2'd0}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               req_i,
  input  logic                           boundary_i,
  input  logic                           ack_i,
  input  logic                           eos_i,
  input  logic                           gate_i,
  input  logic                           mask_we_i,
  input  logic [$clog2(N_SRC)-1:0]       mask_row_i,
  input  logic [N_SRC-1:0]               mask_data_i,
  output logic                           irq_o,
  output logic [$clog2(N_SRC)-1:0]       grant_id_o,
  output logic [N_SRC-1:0]               mask_o,
  output logic [$clog2(N_SRC+1)-1:0]     depth_o
);
  localparam int unsigned ID_W  = $clog2(N_SRC);
  localparam int unsigned DEPTH = N_SRC;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned CTX_W = 1 + ID_W + N_SRC;

  logic [N_SRC-1:0]       pend_q, cur_mask_q, cand, clr;
  logic                   cur_act_q, any;
  logic [ID_W-1:0]        cur_id_q, pick_id;
  logic [N_SRC*N_SRC-1:0] rows;
  logic [CTX_W-1:0]       push_ctx, top_ctx;
  logic [CW-1:0]          depth;
  logic                   take, ret;
  stk_op_e                op;

  irq_mask_bank #(.N_SRC(N_SRC), .ID_W(ID_W), .PROC_RANK(PROC_RANK)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(mask_we_i), .row(mask_row_i),
    .data(mask_data_i), .rows_o(rows)
  );

  assign cand = pend_q & ~cur_mask_q;

  irq_resp_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
    .cand(cand), .any(any), .id(pick_id)
  );

  assign irq_o = gate_i & any;
  assign ret   = eos_i & (depth != '0);
  assign take  = ack_i & irq_o & ~eos_i & (depth < CW'(DEPTH));
  assign op    = ret ? STK_POP : (take ? STK_PUSH : STK_HOLD);

  assign push_ctx = {cur_act_q, cur_id_q, cur_mask_q};

  irq_ctx_stack #(.DEPTH(DEPTH), .W(CTX_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .op(op), .din(push_ctx),
    .top_o(top_ctx), .cnt_o(depth)
  );

  always_comb begin
    clr = '0;
    if (take) clr[pick_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      cur_mask_q <= '0;
      cur_act_q  <= 1'b0;
      cur_id_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | (boundary_i ? req_i : '0);
      if (ret) begin
        {cur_act_q, cur_id_q, cur_mask_q} <= top_ctx;
      end else if (take) begin
        cur_act_q  <= 1'b1;
        cur_id_q   <= pick_id;
        cur_mask_q <= rows[pick_id*N_SRC +: N_SRC];
      end
    end
  end

  assign grant_id_o = pick_id;
  assign mask_o     = cur_mask_q;
  assign depth_o    = depth;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_SRC-1:0]           req_i,
  input logic                       boundary_i,
  input logic                       ack_i,
  input logic                       eos_i,
  input logic                       gate_i,
  input logic                       mask_we_i,
  input logic [$clog2(N_SRC)-1:0]   mask_row_i,
  input logic [N_SRC-1:0]           mask_data_i,
  input logic                       irq_o,
  input logic [$clog2(N_SRC)-1:0]   grant_id_o,
  input logic [N_SRC-1:0]           mask_o,
  input logic [$clog2(N_SRC+1)-1:0] depth_o
);
  localparam int unsigned CW = $clog2(N_SRC + 1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CW'(N_SRC)); // R8
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |-> !irq_o); // R9
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_o[grant_id_o]); // R3
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !eos_i && depth_o < CW'(N_SRC)) |=> depth_o == $past(depth_o) + CW'(1)); // R4
  AST_EOS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && depth_o != '0) |=> depth_o == $past(depth_o) - CW'(1)); // R6
  AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == '0) |-> (mask_o == '0)); // R1
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eos_i) |=> $stable(depth_o)); // R4
endmodule

bind irq_nest_ctrl irq_nest_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req = '0, mdata = '0;
  logic       bnd = 0, ack = 0, eos = 0, gate = 1, mwe = 0;
  logic [1:0] mrow = '0;
  logic       irq;
  logic [1:0] gid;
  logic [3:0] mask;
  logic [2:0] depth;
  int errors = 0, checks = 0;
  int rk [4] = '{0, 3, 2, 1};

  always #5 clk = ~clk;

  irq_nest_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .boundary_i(bnd), .ack_i(ack),
    .eos_i(eos), .gate_i(gate), .mask_we_i(mwe), .mask_row_i(mrow),
    .mask_data_i(mdata), .irq_o(irq), .grant_id_o(gid), .mask_o(mask),
    .depth_o(depth)
  );

  function automatic logic [3:0] exp_row(int s);
    logic [3:0] m;
    for (int t = 0; t < 4; t++) m[t] = (rk[t] >= rk[s]);
    return m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
    bnd = 0; ack = 0; eos = 0; mwe = 0; req = '0;
  endtask

  task automatic do_reset;
    rst_n = 0; gate = 1;
    @(posedge clk); #2; rst_n = 1;
  endtask

  task automatic raise(logic [3:0] r);
    req = r; bnd = 1; tick();
  endtask

  task automatic wmask(int row, logic [3:0] d);
    mwe = 1; mrow = 2'(row); mdata = d; tick();
  endtask

  initial begin
    #200us;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mask", mask, 0); chk("R1 depth", depth, 0); chk("R1 irq", irq, 0);
    // R4 ack with nothing pending
    ack = 1; tick(); chk("R4 idle ack depth", depth, 0);
    // R6 eos at depth 0
    eos = 1; tick(); chk("R6 idle eos depth", depth, 0); chk("R6 idle eos mask", mask, 0);
    // R2 request outside boundary is not latched
    req = 4'b0100; tick(); chk("R2 no boundary irq", irq, 0);
    bnd = 1; tick(); chk("R2 boundary no req", irq, 0);
    raise(4'b0100); tick(); tick();
    chk("R2 held irq", irq, 1); chk("R2 held id", gid, 2);

    // R5/R3 sweep of all row/column pairs of the default masks
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        logic [3:0] em;
        em = exp_row(s);
        do_reset();
        raise(4'(1 << s));
        chk("R3 single grant id", gid, s);
        ack = 1; tick();
        chk("R5 row loaded", mask, em); chk("R4 depth one", depth, 1);
        raise(4'(1 << t));
        chk("R5 preempt allowed", irq, em[t] ? 0 : 1);
        if (!em[t]) chk("R3 preempt id", gid, t);
      end
    end

    // R3 response order among several
    do_reset(); raise(4'b1110); chk("R3 order id", gid, 1);

    // R9 gate closed
    do_reset(); gate = 0; raise(4'b0001);
    chk("R9 gated irq", irq, 0);
    ack = 1; tick(); chk("R9 gated ack", depth, 0);
    gate = 1; #1; chk("R9 pending kept", irq, 1); chk("R9 pending id", gid, 0);

    // R10 nested scenario
    do_reset(); raise(4'b1101);
    chk("R10 first id", gid, 0);
    ack = 1; tick(); chk("R10 L1 mask", mask, 4'b1111); chk("R10 L1 irq", irq, 0);
    eos = 1; tick(); chk("R10 back main", depth, 0); chk("R10 next id", gid, 2);
    ack = 1; tick(); chk("R10 L3 mask", mask, 4'b0110); chk("R10 L4 offered", gid, 3);
    ack = 1; tick(); chk("R10 L4 mask", mask, 4'b1110); chk("R10 depth two", depth, 2);
    raise(4'b0010); chk("R10 L2 blocked", irq, 0);
    eos = 1; tick(); chk("R10 L3 restored", mask, 4'b0110); chk("R10 L2 still blocked", irq, 0);
    eos = 1; tick(); chk("R10 main again", mask, 0); chk("R10 L2 offered", gid, 1);
    ack = 1; tick(); chk("R10 L2 mask", mask, 4'b0010);
    eos = 1; tick(); chk("R10 unwound", depth, 0);

    // R6 eos wins over ack
    do_reset(); raise(4'b0010); ack = 1; tick();
    raise(4'b0100); chk("R6 L3 offered", gid, 2);
    ack = 1; eos = 1; tick();
    chk("R6 eos wins depth", depth, 0); chk("R6 eos wins mask", mask, 0);
    chk("R6 L3 kept", gid, 2); chk("R6 L3 irq", irq, 1);

    // R7 mask write takes effect at next grant only
    do_reset(); raise(4'b0100); ack = 1; tick();
    wmask(2, 4'b1000); chk("R7 live mask unchanged", mask, 4'b0110);
    eos = 1; tick(); raise(4'b0100); ack = 1; tick();
    chk("R7 new row used", mask, 4'b1000);

    // R8 depth cap with self-unmasking rows
    do_reset();
    for (int r = 0; r < 4; r++) wmask(r, 4'b0000);
    raise(4'b1111);
    for (int k = 0; k < 4; k++) begin
      ack = 1; tick(); chk("R8 fill depth", depth, k + 1);
    end
    raise(4'b0001); chk("R8 full irq", irq, 1);
    ack = 1; tick();
    chk("R8 capped depth", depth, 4); chk("R8 pending kept", irq, 1); chk("R8 id", gid, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule